// File: doc/BRIEF.md
# Microcoded Accumulator Computer

This block is a small accumulator machine whose control comes from a 128-word, 20-bit microprogram store. Each control word has three 3-bit operation fields, a 2-bit condition select, a 2-bit branch kind and a 7-bit target address. The three operation fields are decoded separately and all act in the same clock cycle. They move data among an 11-bit address register, an 11-bit program counter, a 16-bit data register and a 16-bit accumulator, which work on a 2048-word, 16-bit main memory.

Each machine word holds an indirect flag in bit 15, an opcode in bits 14..11 and an address in bits 10..0. Four opcodes are carried by fixed microcode routines: add to AC, branch when AC is negative, store AC, and exchange AC with memory. A shared fetch routine starts at control address 64. An indirect-address subroutine starts at control address 67. The sequencer picks the next control address from one of four sources: the increment, the target field, the saved return address, or the opcode map. Both the main memory and the microprogram are filled inside the block, and main memory is loaded again on every reset. A read-only peek port shows any memory word so the outcome of the built-in program can be observed.

Top module: `uacc_cpu`

## Requirements
- R1: While reset is held and just after it is released, the control address is 64 and PC, AC, AR and DR are all zero.
- R2: The fetch routine takes three cycles at control addresses 64, 65 and 66. At 64, AR gets PC. At 65, DR gets M[AR] and PC is incremented. At 66, AR gets DR[10:0].
- R3: At control address 66 the next control address is {0, DR[14:11], 00}, so the routine for opcode n begins at 4n.
- R4: Opcode 0000 adds M[EA] to AC, modulo 2^16.
- R5: When bit 15 of the instruction is 1, the routine calls the subroutine at 67. That subroutine loads DR from M[AR], then sets AR to DR[10:0], then returns to the control word after the call. EA is then M[address][10:0].
- R6: Opcode 0001 sets PC to EA when AC[15] is 1. Otherwise PC keeps the already incremented value. After the return-address step (control address 7), PC equals the AR of the cycle before.
- R7: Opcode 0010 writes AC to M[EA] and leaves AC unchanged.
- R8: Opcode 0011 loads the old M[EA] into AC and writes the old AC into M[EA]. The swap of AC and DR happens in one cycle, and each register receives the other's value from before the edge.
- R9: After reset, the peek port returns the preloaded words. The program is at 0..7 and 20..21. The data is 100:5, 101:102, 102:7, 103:3, 105:FFF0h, 106:20, 107:1234h and 108:110. Every other word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, reloads memory |
| peek_addr_i | input | 11 | Memory word to observe |
| peek_data_o | output | 16 | Combinational contents of that word |
| ac_o | output | 16 | Accumulator |
| dr_o | output | 16 | Data register |
| pc_o | output | 11 | Program counter |
| ar_o | output | 11 | Address register |
| car_o | output | 7 | Control address register |

## Verification
Two things can land on the same edge. At control address 14, the accumulator-to-DR transfer and the DR-to-accumulator transfer fire together. At control address 65, the memory read into DR and the PC increment fire together. The built-in program reaches both, through an exchange instruction and through every fetch. A behavioural step model in the bench predicts every register after each edge, using only pre-edge values. Any ordering fault, such as a swap that copies the same value twice, shows up as a mismatch in the very next cycle.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 16;
    localparam int UADDR_W = 7;
    localparam int FLD_W   = 3;

    localparam logic [UADDR_W-1:0] FETCH_UA = 7'd64;
    localparam logic [UADDR_W-1:0] INDIR_UA = 7'd67;

    typedef enum logic [1:0] {CD_ALWAYS, CD_IBIT, CD_SIGN, CD_ZERO} cond_e;
    typedef enum logic [1:0] {BR_JMP, BR_CALL, BR_RET, BR_MAP} brk_e;

    typedef struct packed {
        logic [FLD_W-1:0]   f1;
        logic [FLD_W-1:0]   f2;
        logic [FLD_W-1:0]   f3;
        cond_e              cd;
        brk_e               br;
        logic [UADDR_W-1:0] ad;
    } uword_t;

    function automatic uword_t mk(input logic [2:0] a, input logic [2:0] b,
                                  input logic [2:0] c, input cond_e cd,
                                  input brk_e br, input logic [6:0] ad);
        uword_t w;
        w.f1 = a; w.f2 = b; w.f3 = c; w.cd = cd; w.br = br; w.ad = ad;
        return w;
    endfunction

    // Microprogram contents
    function automatic uword_t ucode(input logic [UADDR_W-1:0] a);
        case (a)
            7'd0:  return mk(3'd0, 3'd0, 3'd0, CD_IBIT,   BR_CALL, INDIR_UA);
            7'd1:  return mk(3'd0, 3'd4, 3'd0, CD_ALWAYS, BR_JMP,  7'd2);
            7'd2:  return mk(3'd1, 3'd0, 3'd0, CD_ALWAYS, BR_JMP,  FETCH_UA);
            7'd4:  return mk(3'd0, 3'd0, 3'd0, CD_SIGN,   BR_JMP,  7'd6);
            7'd6:  return mk(3'd0, 3'd0, 3'd0, CD_IBIT,   BR_CALL, INDIR_UA);
            7'd7:  return mk(3'd0, 3'd0, 3'd6, CD_ALWAYS, BR_JMP,  FETCH_UA);
            7'd8:  return mk(3'd0, 3'd0, 3'd0, CD_IBIT,   BR_CALL, INDIR_UA);
            7'd9:  return mk(3'd0, 3'd5, 3'd0, CD_ALWAYS, BR_JMP,  7'd10);
            7'd10: return mk(3'd7, 3'd0, 3'd0, CD_ALWAYS, BR_JMP,  FETCH_UA);
            7'd12: return mk(3'd0, 3'd0, 3'd0, CD_IBIT,   BR_CALL, INDIR_UA);
            7'd13: return mk(3'd0, 3'd4, 3'd0, CD_ALWAYS, BR_JMP,  7'd14);
            7'd14: return mk(3'd4, 3'd5, 3'd0, CD_ALWAYS, BR_JMP,  7'd15);
            7'd15: return mk(3'd7, 3'd0, 3'd0, CD_ALWAYS, BR_JMP,  FETCH_UA);
            7'd64: return mk(3'd6, 3'd0, 3'd0, CD_ALWAYS, BR_JMP,  7'd65);
            7'd65: return mk(3'd0, 3'd4, 3'd5, CD_ALWAYS, BR_JMP,  7'd66);
            7'd66: return mk(3'd5, 3'd0, 3'd0, CD_ALWAYS, BR_MAP,  7'd0);
            7'd67: return mk(3'd0, 3'd4, 3'd0, CD_ALWAYS, BR_JMP,  7'd68);
            7'd68: return mk(3'd5, 3'd0, 3'd0, CD_ALWAYS, BR_RET,  7'd0);
            default: return mk(3'd0, 3'd0, 3'd0, CD_ALWAYS, BR_JMP, FETCH_UA);
        endcase
    endfunction

    // Main memory preload: program and data
    function automatic logic [DATA_W-1:0] boot_word(input logic [ADDR_W-1:0] a);
        case (a)
            11'd0:   return 16'h0064;
            11'd1:   return 16'h8065;
            11'd2:   return 16'h1867;
            11'd3:   return 16'h1068;
            11'd4:   return 16'h080A;
            11'd5:   return 16'h0069;
            11'd6:   return 16'h886A;
            11'd7:   return 16'h106B;
            11'd20:  return 16'h906C;
            11'd21:  return 16'h0815;
            11'd100: return 16'd5;
            11'd101: return 16'd102;
            11'd102: return 16'd7;
            11'd103: return 16'd3;
            11'd105: return 16'hFFF0;
            11'd106: return 16'd20;
            11'd107: return 16'h1234;
            11'd108: return 16'd110;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/uacc_dec.sv
module uacc_dec #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] code_i,
    output logic [N-1:1] sel_o
);
    for (genvar k = 1; k < N; k++) begin : g_line
        assign sel_o[k] = (code_i == W'(k));
    end
endmodule

// File: rtl/uacc_seq.sv
module uacc_seq
    import uacc_pkg::*;
#(
    parameter int UAW = UADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  cond_e          cd_i,
    input  brk_e           br_i,
    input  logic [UAW-1:0] ad_i,
    input  logic           ibit_i,
    input  logic           sign_i,
    input  logic           zero_i,
    input  logic [3:0]     op_i,
    output logic [UAW-1:0] car_o
);
    typedef struct packed {
        logic [UAW-1:0] car;
        logic [UAW-1:0] sbr;
    } seq_t;

    seq_t st_q, st_d;
    logic test;

    always_comb begin
        case (cd_i)
            CD_ALWAYS: test = 1'b1;
            CD_IBIT:   test = ibit_i;
            CD_SIGN:   test = sign_i;
            default:   test = zero_i;
        endcase
        st_d = st_q;
        st_d.car = st_q.car + 1'b1;
        case (br_i)
            BR_JMP:  if (test) st_d.car = ad_i;
            BR_CALL: if (test) begin
                st_d.car = ad_i;
                st_d.sbr = st_q.car + 1'b1;
            end
            BR_RET:  st_d.car = st_q.sbr;
            default: st_d.car = UAW'({op_i, 2'b00});
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.car <= FETCH_UA;
            st_q.sbr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign car_o = st_q.car;
endmodule

// File: rtl/uacc_dp.sv
module uacc_dp
    import uacc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:1]    f1_i,
    input  logic [7:1]    f2_i,
    input  logic [7:1]    f3_i,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic [DW-1:0] ac_o,
    output logic [DW-1:0] dr_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] ar_o
);
    typedef struct packed {
        logic [DW-1:0] ac;
        logic [DW-1:0] dr;
        logic [AW-1:0] pc;
        logic [AW-1:0] ar;
    } regs_t;

    regs_t r_q, r_d;

    // Every right-hand side reads r_q, so all fields see pre-edge values.
    always_comb begin
        r_d = r_q;
        if (f1_i[1]) r_d.ac = r_q.ac + r_q.dr;
        if (f1_i[2]) r_d.ac = '0;
        if (f1_i[3]) r_d.ac = r_q.ac + 1'b1;
        if (f1_i[4]) r_d.ac = r_q.dr;
        if (f1_i[5]) r_d.ar = r_q.dr[AW-1:0];
        if (f1_i[6]) r_d.ar = r_q.pc;
        if (f2_i[1]) r_d.ac = r_q.ac - r_q.dr;
        if (f2_i[2]) r_d.ac = r_q.ac | r_q.dr;
        if (f2_i[3]) r_d.ac = r_q.ac & r_q.dr;
        if (f2_i[4]) r_d.dr = rdata_i;
        if (f2_i[5]) r_d.dr = r_q.ac;
        if (f2_i[6]) r_d.dr = r_q.dr + 1'b1;
        if (f2_i[7]) r_d.dr[AW-1:0] = r_q.pc;
        if (f3_i[1]) r_d.ac = r_q.ac ^ r_q.dr;
        if (f3_i[2]) r_d.ac = ~r_q.ac;
        if (f3_i[3]) r_d.ac = {r_q.ac[DW-2:0], 1'b0};
        if (f3_i[4]) r_d.ac = {1'b0, r_q.ac[DW-1:1]};
        if (f3_i[5]) r_d.pc = r_q.pc + 1'b1;
        if (f3_i[6]) r_d.pc = r_q.ar;
        if (f3_i[7]) r_d.pc = r_q.pc;   // reserved code: no transfer
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign we_o = f1_i[7];
    assign ac_o = r_q.ac;
    assign dr_o = r_q.dr;
    assign pc_o = r_q.pc;
    assign ar_o = r_q.ar;
endmodule

// File: rtl/uacc_mem.sv
module uacc_mem
    import uacc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [AW-1:0] peek_addr_i,
    output logic [DW-1:0] peek_data_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= boot_word(AW'(i));
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o     = mem_q[addr_i];
    assign peek_data_o = mem_q[peek_addr_i];
endmodule

// File: rtl/uacc_cpu.sv
module uacc_cpu
    import uacc_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int UAW = UADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] peek_addr_i,
    output logic [DW-1:0] peek_data_o,
    output logic [DW-1:0] ac_o,
    output logic [DW-1:0] dr_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] ar_o,
    output logic [UAW-1:0] car_o
);
    localparam int NF = 3;

    uword_t          uw;
    logic [2:0]      fld [NF];
    logic [7:1]      sel [NF];
    logic [DW-1:0]   rdata;
    logic            we;
    logic            ac_zero;

    assign uw     = ucode(car_o);
    assign fld[0] = uw.f1;
    assign fld[1] = uw.f2;
    assign fld[2] = uw.f3;

    for (genvar g = 0; g < NF; g++) begin : g_dec
        uacc_dec #(.W(FLD_W)) u_dec (.code_i(fld[g]), .sel_o(sel[g]));
    end

    assign ac_zero = (ac_o == '0);

    uacc_seq #(.UAW(UAW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cd_i(uw.cd), .br_i(uw.br), .ad_i(uw.ad),
        .ibit_i(dr_o[DW-1]), .sign_i(ac_o[DW-1]), .zero_i(ac_zero),
        .op_i(dr_o[DW-2:DW-5]),
        .car_o(car_o)
    );

    uacc_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .f1_i(sel[0]), .f2_i(sel[1]), .f3_i(sel[2]),
        .rdata_i(rdata), .we_o(we),
        .ac_o(ac_o), .dr_o(dr_o), .pc_o(pc_o), .ar_o(ar_o)
    );

    uacc_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .addr_i(ar_o), .wdata_i(dr_o), .rdata_o(rdata),
        .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o)
    );
endmodule

// File: rtl/uacc_chk.sv
module uacc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  car,
    input logic [15:0] ac,
    input logic [15:0] dr,
    input logic [10:0] pc,
    input logic [10:0] ar
);
    // R2: fetch steps follow each other
    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd64) |=> (car == 7'd65));
    // R2: first fetch step copies PC into AR
    a_r2_pc_to_ar: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd64) |=> (ar == $past(pc)));
    // R2: second fetch step advances PC
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd65) |=> (pc == $past(pc) + 11'd1));
    // R3: opcode map
    a_r3_map: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd66) |=> (car == {1'b0, $past(dr[14:11]), 2'b00}));
    // R5: return lands right after a call site
    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd68) |=> (car == 7'd1 || car == 7'd7 || car == 7'd9 || car == 7'd13));
    // R6: branch target taken from AR
    a_r6_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd7) |=> (pc == $past(ar)));
    // R8: one-cycle swap
    a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (car == 7'd14) |=> (ac == $past(dr) && dr == $past(ac)));
endmodule

bind uacc_cpu uacc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .car(car_o),
    .ac(ac_o), .dr(dr_o), .pc(pc_o), .ar(ar_o)
);

// File: tb/uacc_cpu_tb.sv
module uacc_cpu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] peek_addr = '0;
    logic [15:0] peek_data, ac, dr;
    logic [10:0] pc, ar;
    logic [6:0]  car;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uacc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .peek_addr_i(peek_addr), .peek_data_o(peek_data),
        .ac_o(ac), .dr_o(dr), .pc_o(pc), .ar_o(ar), .car_o(car)
    );

    // Reference model state
    logic [15:0] m_ac, m_dr;
    logic [10:0] m_pc, m_ar;
    int          m_car, m_sbr;
    logic [15:0] m_mem [2048];

    function automatic logic [15:0] prog(input int a);
        case (a)
            0: return 16'h0064;   1: return 16'h8065;   2: return 16'h1867;
            3: return 16'h1068;   4: return 16'h080A;   5: return 16'h0069;
            6: return 16'h886A;   7: return 16'h106B;   20: return 16'h906C;
            21: return 16'h0815;  100: return 16'd5;    101: return 16'd102;
            102: return 16'd7;    103: return 16'd3;    105: return 16'hFFF0;
            106: return 16'd20;   107: return 16'h1234; 108: return 16'd110;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset();
        m_ac = '0; m_dr = '0; m_pc = '0; m_ar = '0; m_car = 64; m_sbr = 0;
        for (int i = 0; i < 2048; i++) m_mem[i] = prog(i);
    endtask

    task automatic call_if_indirect();
        if (m_dr[15]) begin m_sbr = m_car + 1; m_car = 67; end
        else m_car = m_car + 1;
    endtask

    // One control step, behaviourally
    task automatic model_step();
        logic [15:0] t;
        case (m_car)
            64: begin m_ar = m_pc; m_car = 65; end
            65: begin m_dr = m_mem[m_ar]; m_pc = m_pc + 1; m_car = 66; end
            66: begin m_ar = m_dr[10:0]; m_car = 4 * int'(m_dr[14:11]); end
            67: begin m_dr = m_mem[m_ar]; m_car = 68; end
            68: begin m_ar = m_dr[10:0]; m_car = m_sbr; end
            0, 6, 8, 12: call_if_indirect();
            1, 13: begin m_dr = m_mem[m_ar]; m_car = m_car + 1; end
            2: begin m_ac = m_ac + m_dr; m_car = 64; end
            4: m_car = m_ac[15] ? 6 : 5;
            7: begin m_pc = m_ar; m_car = 64; end
            9: begin m_dr = m_ac; m_car = 10; end
            10, 15: begin m_mem[m_ar] = m_dr; m_car = 64; end
            14: begin t = m_ac; m_ac = m_dr; m_dr = t; m_car = 15; end
            default: m_car = 64;
        endcase
    endtask

    task automatic cmp_regs(input string req, input int cyc);
        compared++;
        if (ac !== m_ac || dr !== m_dr || pc !== m_pc || ar !== m_ar || int'(car) != m_car) begin
            mismatched++;
            $display("FAIL %s cycle %0d: got car=%0d ac=%h dr=%h pc=%0d ar=%0d exp car=%0d ac=%h dr=%h pc=%0d ar=%0d",
                     req, cyc, car, ac, dr, pc, ar, m_car, m_ac, m_dr, m_pc, m_ar);
        end
    endtask

    task automatic cmp_mem(input string req, input int a, input logic [15:0] exp);
        peek_addr = 11'(a);
        #1;
        compared++;
        if (peek_data !== exp) begin
            mismatched++;
            $display("FAIL %s M[%0d]: got %h exp %h", req, a, peek_data, exp);
        end
    endtask

    task automatic cmp_val(input string req, input logic [15:0] got, input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        cmp_regs("R1", -1);
        rst_n = 1'b1;
        cmp_regs("R1", 0);
        // R9: preload visible through the peek port
        cmp_mem("R9", 0, 16'h0064);
        cmp_mem("R9", 105, 16'hFFF0);
        cmp_mem("R9", 2047, 16'h0000);
        for (int c = 1; c <= RUN_CYCLES; c++) begin
            model_step();
            @(negedge clk);
            // R2..R8: every register after every edge
            cmp_regs("R2-step", c);
        end
        // End results of the program
        cmp_val("R4 R6 final AC", ac, 16'hFFF3);
        cmp_val("R6 branch loop PC", {5'd0, pc}, 16'd21);
        cmp_mem("R8 exchanged word", 103, 16'd12);
        cmp_mem("R7 stored word", 104, 16'd3);
        cmp_mem("R5 R7 indirect store", 110, 16'hFFF3);
        cmp_mem("R6 skipped store", 107, 16'h1234);
        for (int a = 0; a < 128; a++) cmp_mem("R9 sweep", a, m_mem[a]);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule